// File: doc/BRIEF.md
# Sector Read DMA Controller

This block moves one disk sector into main memory without CPU involvement. Software programs three registers through a small register port: a block number, a destination byte address, and a command code. When the command is the read opcode, the controller walks the addressed sector in an internal sector store. It issues one bus-master write per data word on a valid/ready memory port, and raises an interrupt line once the last word has been accepted. The interrupt is cleared by a write to the status register.

A sector is 512 bytes, so with the default 32-bit data path a transfer is 128 write beats. The sector store is a read-only, computed image indexed by block number and word index. Its contents follow a fixed formula, so any transfer can be predicted exactly. While a transfer runs the controller reports busy and ignores all programming writes except to the status register.

Top module: `sector_dma`

## Requirements
- R1: After reset the status register reads 0, `irq` is low and `mem_req` is low.
- R2: Register word offsets on `reg_addr`: 0 is command (opcode in bits 7:0, reads as 0), 1 is block number, 2 is destination address, 3 is status. Block number and destination read back the value last written.
- R3: Writing opcode 8'h20 to the command register while idle starts a transfer. From the next cycle, status bit 0 (busy) reads 1 and `mem_req` is high.
- R4: Writing any other opcode while idle sets status bit 2 (error) and starts no transfer. Writing the status register with bit 2 set clears the error bit.
- R5: A transfer makes exactly 512/(DATA_W/8) accepted write beats. Beat i goes to address dest + i*(DATA_W/8).
- R6: Beat i of block b carries the word (b*32'h01000193) ^ (i*32'h00010001) ^ 32'hA5A50000.
- R7: While `mem_req` is high and `mem_ready` is low, `mem_req`, `mem_addr` and `mem_wdata` hold their values.
- R8: On the clock edge that accepts the last beat, busy clears and `irq` (also status bit 1) rises.
- R9: `irq` stays high until the status register is written with bit 1 set. A status write with bit 1 clear leaves it high.
- R10: While busy, writes to the command, block number and destination registers have no effect. This holds for both good and bad opcodes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word offset |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data (combinational) |
| mem_req | output | 1 | Memory write request |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_ready | input | 1 | Memory accepts the current beat |
| irq | output | 1 | Transfer-complete interrupt |

## Verification
The bench runs transfers under three memory-ready patterns: always ready, ready one cycle in three, and pseudo-random. An address or data register that advanced on a stalled cycle would show up as a skipped or duplicated word. Mid-transfer writes to every programming register, including a second read command and a bad opcode, are checked by readback and by the beat count. A controller that restarted or retargeted would write more than one sector's worth of beats or wrong data, and one that flagged the bad opcode would show the error bit. The bench also checks that the interrupt holds across idle cycles and an unrelated status write, that a bad opcode sets the error bit without moving data, and that a destination near the top of the address space still steps evenly.

// File: rtl/sdma_pkg.sv
package sdma_pkg;

  localparam logic [7:0] OP_READ = 8'h20;

  typedef enum logic [1:0] {
    REG_CMD    = 2'd0,
    REG_BLOCK  = 2'd1,
    REG_DEST   = 2'd2,
    REG_STATUS = 2'd3
  } reg_sel_e;

  typedef enum logic {
    ENG_IDLE = 1'b0,
    ENG_XFER = 1'b1
  } eng_state_e;

  // Content of word idx in sector blk of the computed sector image.
  function automatic logic [31:0] sector_word(input logic [31:0] blk,
                                              input logic [31:0] idx);
    return (blk * 32'h0100_0193) ^ (idx * 32'h0001_0001) ^ 32'hA5A5_0000;
  endfunction

endpackage

// File: rtl/sdma_regs.sv
module sdma_regs
  import sdma_pkg::*;
#(
  parameter int BLOCK_W = 3,
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic [1:0]         reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  input  logic               busy,
  input  logic               xfer_done,
  output logic               cmd_start,
  output logic               cmd_bad,
  output logic               irq_clr,
  output logic               irq_q,
  output logic               err_q,
  output logic [BLOCK_W-1:0] blk_q,
  output logic [ADDR_W-1:0]  dest_q
);

  logic wr_cmd, wr_blk, wr_dest, wr_stat, err_clr;

  assign wr_cmd  = reg_wr && (reg_addr == REG_CMD)    && !busy;
  assign wr_blk  = reg_wr && (reg_addr == REG_BLOCK)  && !busy;
  assign wr_dest = reg_wr && (reg_addr == REG_DEST)   && !busy;
  assign wr_stat = reg_wr && (reg_addr == REG_STATUS);

  assign cmd_start = wr_cmd && (reg_wdata[7:0] == OP_READ);
  assign cmd_bad   = wr_cmd && (reg_wdata[7:0] != OP_READ);
  assign irq_clr   = wr_stat && reg_wdata[1];
  assign err_clr   = wr_stat && reg_wdata[2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      blk_q  <= '0;
      dest_q <= '0;
      irq_q  <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      if (wr_blk)  blk_q  <= reg_wdata[BLOCK_W-1:0];
      if (wr_dest) dest_q <= reg_wdata[ADDR_W-1:0];
      // completion wins over a clear in the same cycle
      if (xfer_done)    irq_q <= 1'b1;
      else if (irq_clr) irq_q <= 1'b0;
      if (cmd_bad)      err_q <= 1'b1;
      else if (err_clr) err_q <= 1'b0;
    end
  end

  always_comb begin
    unique case (reg_addr)
      REG_CMD:    reg_rdata = '0;
      REG_BLOCK:  reg_rdata = DATA_W'(blk_q);
      REG_DEST:   reg_rdata = DATA_W'(dest_q);
      default:    reg_rdata = DATA_W'({err_q, irq_q, busy});
    endcase
  end

endmodule

// File: rtl/sdma_store.sv
module sdma_store
  import sdma_pkg::*;
#(
  parameter int BLOCK_W = 3,
  parameter int IDX_W   = 7,
  parameter int DATA_W  = 32
) (
  input  logic [BLOCK_W-1:0] blk,
  input  logic [IDX_W-1:0]   idx,
  output logic [DATA_W-1:0]  word
);

  assign word = DATA_W'(sector_word(32'(blk), 32'(idx)));

endmodule

// File: rtl/sdma_engine.sv
module sdma_engine
  import sdma_pkg::*;
#(
  parameter int BLOCK_W = 3,
  parameter int ADDR_W  = 32,
  parameter int IDX_W   = 7,
  parameter int WORDS   = 128,
  parameter int STEP    = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [BLOCK_W-1:0] blk_in,
  input  logic [ADDR_W-1:0]  dest_in,
  input  logic               mem_ready,
  output logic               mem_req,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic [BLOCK_W-1:0] cur_blk,
  output logic [IDX_W-1:0]   cur_idx,
  output logic               busy,
  output logic               xfer_done
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORDS - 1);

  eng_state_e state;
  logic       beat_ok;

  assign busy      = (state == ENG_XFER);
  assign mem_req   = busy;
  assign beat_ok   = busy && mem_ready;
  assign xfer_done = beat_ok && (cur_idx == LAST_IDX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ENG_IDLE;
      mem_addr <= '0;
      cur_blk  <= '0;
      cur_idx  <= '0;
    end else if (state == ENG_IDLE) begin
      if (start) begin
        state    <= ENG_XFER;
        mem_addr <= dest_in;
        cur_blk  <= blk_in;
        cur_idx  <= '0;
      end
    end else if (beat_ok) begin
      if (xfer_done) begin
        state <= ENG_IDLE;
      end else begin
        cur_idx  <= cur_idx + 1'b1;
        mem_addr <= mem_addr + ADDR_W'(STEP);
      end
    end
  end

endmodule

// File: rtl/sector_dma.sv
module sector_dma
  import sdma_pkg::*;
#(
  parameter int BLOCK_W      = 3,
  parameter int ADDR_W       = 32,
  parameter int DATA_W       = 32,
  parameter int SECTOR_BYTES = 512
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ready,
  output logic              irq
);

  localparam int STEP  = DATA_W / 8;
  localparam int WORDS = SECTOR_BYTES / STEP;
  localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1;

  logic               cmd_start, cmd_bad, irq_clr, err_flag;
  logic               busy, xfer_done;
  logic [BLOCK_W-1:0] blk_q, cur_blk;
  logic [ADDR_W-1:0]  dest_q;
  logic [IDX_W-1:0]   cur_idx;

  sdma_regs #(.BLOCK_W(BLOCK_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy),
    .xfer_done(xfer_done), .cmd_start(cmd_start), .cmd_bad(cmd_bad),
    .irq_clr(irq_clr), .irq_q(irq), .err_q(err_flag), .blk_q(blk_q),
    .dest_q(dest_q)
  );

  sdma_engine #(.BLOCK_W(BLOCK_W), .ADDR_W(ADDR_W), .IDX_W(IDX_W),
                .WORDS(WORDS), .STEP(STEP)) u_engine (
    .clk(clk), .rst_n(rst_n), .start(cmd_start), .blk_in(blk_q),
    .dest_in(dest_q), .mem_ready(mem_ready), .mem_req(mem_req),
    .mem_addr(mem_addr), .cur_blk(cur_blk), .cur_idx(cur_idx),
    .busy(busy), .xfer_done(xfer_done)
  );

  sdma_store #(.BLOCK_W(BLOCK_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_store (
    .blk(cur_blk), .idx(cur_idx), .word(mem_wdata)
  );

endmodule

// File: rtl/sdma_chk.sv
module sdma_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_req,
  input logic              mem_ready,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              irq,
  input logic              busy,
  input logic              err_flag,
  input logic              cmd_start,
  input logic              cmd_bad,
  input logic              xfer_done,
  input logic              irq_clr
);

  a_r7_hold_until_ready: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_wdata));

  a_r5_addr_stride: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ready && !xfer_done |=>
      mem_req && (mem_addr == $past(mem_addr) + ADDR_W'(DATA_W / 8)));

  a_r8_done_raises_irq: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> irq && !busy && !mem_req);

  a_r3_start_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_start |=> busy && mem_req);

  a_r10_busy_blocks_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !cmd_start && !cmd_bad);

  a_r9_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !irq_clr |=> irq);

  a_r9_irq_clears: assert property (@(posedge clk) disable iff (!rst_n)
    irq_clr && !xfer_done |=> !irq);

  a_r4_bad_sets_err: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_bad |=> err_flag && !busy);

endmodule

bind sector_dma sdma_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_ready(mem_ready),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .irq(irq), .busy(busy),
  .err_flag(err_flag), .cmd_start(cmd_start), .cmd_bad(cmd_bad),
  .xfer_done(xfer_done), .irq_clr(irq_clr)
);

// File: tb/sector_dma_tb.sv
module sector_dma_tb;

  localparam int CLK_PERIOD = 10;
  localparam int BEATS      = 128;
  localparam int NVEC       = 4;
  // {block[7:0], dest[31:0], ready_mode[7:0]}
  localparam logic [47:0] VEC [NVEC] = '{
    {8'd0, 32'h0000_1000, 8'd0},
    {8'd5, 32'h0002_0400, 8'd1},
    {8'd7, 32'hFFFF_FE00, 8'd2},
    {8'd3, 32'h0000_0804, 8'd2}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic [31:0] mem_wdata;
  logic        mem_ready = 1'b1;
  logic        irq;

  int tests = 0;
  int fails = 0;
  int ready_mode = 0;
  int rdy_cnt = 0;
  logic [15:0] lfsr = 16'hACE1;

  int mon_total = 0;
  int mon_err = 0;
  int base_total = 0;
  logic [31:0] exp_blk = '0;
  logic [31:0] exp_dest = '0;

  sector_dma u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ready(mem_ready),
    .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] model_word(input logic [31:0] b, input int i);
    logic [15:0] h;
    h = 16'(i);
    return (b * 32'd16777619) ^ {h, h} ^ 32'hA5A50000;
  endfunction

  always @(negedge clk) begin
    rdy_cnt <= rdy_cnt + 1;
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    case (ready_mode)
      0: mem_ready <= 1'b1;
      1: mem_ready <= (rdy_cnt % 3 == 0);
      default: mem_ready <= lfsr[0];
    endcase
  end

  always @(posedge clk) begin
    if (rst_n && mem_req && mem_ready) begin
      int i;
      i = mon_total - base_total;
      if (mem_addr !== exp_dest + 32'(i * 4) || mem_wdata !== model_word(exp_blk, i))
        mon_err <= mon_err + 1;
      mon_total <= mon_total + 1;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic arm(input logic [31:0] b, input logic [31:0] dst);
    exp_blk = b; exp_dest = dst; base_total = mon_total;
  endtask

  task automatic wait_irq();
    for (int k = 0; k < 3000; k++) begin
      if (irq) break;
      @(negedge clk);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int snap_err;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    rd(2'd3, v); check("R1 status after reset", v, 32'h0);
    check("R1 irq after reset", {31'd0, irq}, 32'h0);
    check("R1 mem_req after reset", {31'd0, mem_req}, 32'h0);

    // table-driven transfers
    for (int n = 0; n < NVEC; n++) begin
      ready_mode = int'(VEC[n][7:0]);
      wr(2'd1, {24'd0, VEC[n][47:40]});
      wr(2'd2, VEC[n][39:8]);
      rd(2'd1, v); check("R2 block readback", v, {24'd0, VEC[n][47:40]});
      rd(2'd2, v); check("R2 dest readback", v, VEC[n][39:8]);
      arm({24'd0, VEC[n][47:40]}, VEC[n][39:8]);
      snap_err = mon_err;
      wr(2'd0, 32'h20);
      rd(2'd3, v); check("R3 busy after start", v & 32'h1, 32'h1);
      wait_irq();
      @(negedge clk);
      check("R5 beat count", 32'(mon_total - base_total), 32'(BEATS));
      check("R6 beat data/address mismatches", 32'(mon_err - snap_err), 32'h0);
      rd(2'd3, v); check("R8 status after done", v, 32'h2);
      wr(2'd3, 32'h2);
      check("R9 irq cleared", {31'd0, irq}, 32'h0);
    end

    // bad opcode
    ready_mode = 0;
    arm(0, 0);
    wr(2'd0, 32'h13);
    rd(2'd3, v); check("R4 error bit set", v, 32'h4);
    repeat (10) @(negedge clk);
    check("R4 no beats after bad opcode", 32'(mon_total - base_total), 32'h0);
    wr(2'd3, 32'h4);
    rd(2'd3, v); check("R4 error cleared", v, 32'h0);

    // writes while busy are ignored
    ready_mode = 1;
    wr(2'd1, 32'd2);
    wr(2'd2, 32'h0000_3000);
    arm(32'd2, 32'h0000_3000);
    snap_err = mon_err;
    wr(2'd0, 32'h20);
    wr(2'd1, 32'd6);
    wr(2'd2, 32'h0000_9000);
    wr(2'd0, 32'h20);
    wr(2'd0, 32'h55);
    rd(2'd1, v); check("R10 block unchanged while busy", v, 32'd2);
    rd(2'd2, v); check("R10 dest unchanged while busy", v, 32'h0000_3000);
    rd(2'd3, v); check("R10 no error from busy write", v & 32'h4, 32'h0);
    wait_irq();
    repeat (20) @(negedge clk);
    check("R10 single sector moved", 32'(mon_total - base_total), 32'(BEATS));
    check("R10 original sector data", 32'(mon_err - snap_err), 32'h0);

    // interrupt holds until the proper clear bit
    check("R9 irq held idle", {31'd0, irq}, 32'h1);
    wr(2'd3, 32'h4);
    check("R9 irq kept on unrelated status write", {31'd0, irq}, 32'h1);
    rd(2'd0, v); check("R2 command reads zero", v, 32'h0);
    wr(2'd3, 32'h2);
    rd(2'd3, v); check("R9 status clear", v, 32'h0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule